// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces one clamp-gate strobe per video line for an external analog-to-digital converter, so that the converter can restore the black level during the back porch. Each falling edge of the active-low horizontal sync input restarts a 10-bit line counter. The strobe is high while that counter lies inside a window that software programs with a start count and an end count.

Each count is 10 bits wide and is written over a byte-wide write port in two parts: a low byte, and a two-bit upper part at a separate address. Writes go into holding registers. These are copied into the working window only on a sync falling edge, so the pulse of the current line never changes part-way through. If no further sync arrives, the counter stops at its maximum value, and no second pulse appears on the same line.

Top module: `hsync_clamp_gen`

## Requirements
- R1: After reset, `clamp_gate` stays low until the first detected sync falling edge. The start count resets to 0 and the end count resets to 82 (low byte 0x52, upper part 0).
- R2: A falling edge is detected at a clock edge where `hsync_n` sampled 1 on the previous edge and 0 on this one. The counter reads 0 in the cycle after that edge and rises by one each cycle after that. `clamp_gate` is high in every cycle where start <= count < end.
- R3: A write with `wr_en`=1 stores `wr_data` by `wr_addr`. Address 0 takes the start low byte and address 1 takes start[9:8] from `wr_data[1:0]`. Address 2 takes the end low byte and address 3 takes end[9:8] from `wr_data[1:0]`. `wr_data[7:2]` has no effect at addresses 1 and 3.
- R4: With the reset values, the first line gives a pulse of 82 clocks, starting at count 0.
- R5: When end <= start, no pulse is produced on that line.
- R6: The counter saturates at 1023 and does not wrap. The strobe is low at count 1023, and no second pulse occurs without a new falling edge.
- R7: Written values take effect only from the next sync falling edge. A write in mid-line leaves that line's pulse unchanged.
- R8: Holding `hsync_n` low, or a rising edge of `hsync_n`, does not restart the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | input | 1 | Horizontal sync, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 start low, 1 start high, 2 end low, 3 end high |
| wr_data | input | 8 | Write data byte |
| clamp_gate | output | 1 | Clamp-gate strobe to the converter |

## Verification
The strobe is a combinational decode of registered state. A falling edge that is sampled at clock edge E puts count k in the cycle after edge E+k. The bench therefore drives `hsync_n` low at a falling clock edge and samples `clamp_gate` at each following falling clock edge, where sample number k corresponds to count k. For each line it measures the index of the first high sample and the number of high samples, over 1100 samples, which runs well past saturation. Each write is captured one edge after it is driven, but it only reaches the window at the next falling edge of sync. The mid-line write test therefore expects the old width on the current line and the new width on the following line.

// File: rtl/hsync_clamp_gen.sv
module hsync_clamp_gen #(
  parameter int CNT_W     = 10,
  parameter int END_RESET = 82
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hsync_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       clamp_gate
);
  localparam int             HI_W     = CNT_W - 8;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] END_INIT = CNT_W'(END_RESET);

  logic             hs_prev;
  logic             hs_fall;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] start_hold, end_hold;
  logic [CNT_W-1:0] start_act, end_act;

  assign hs_fall = hs_prev & ~hsync_n;

  always_ff @(posedge clk) begin
    if (rst) hs_prev <= 1'b1;
    else     hs_prev <= hsync_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_hold <= '0;
      end_hold   <= END_INIT;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: start_hold[7:0]       <= wr_data;
        2'd1: start_hold[CNT_W-1:8] <= wr_data[HI_W-1:0];
        2'd2: end_hold[7:0]         <= wr_data;
        default: end_hold[CNT_W-1:8] <= wr_data[HI_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_act <= '0;
      end_act   <= END_INIT;
      cnt       <= CNT_MAX;
    end else if (hs_fall) begin
      start_act <= start_hold;
      end_act   <= end_hold;
      cnt       <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign clamp_gate = (cnt >= start_act) && (cnt < end_act);

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    hs_fall |=> cnt == '0); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!hs_fall && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R8
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!hs_fall && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R6
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    cnt == CNT_MAX |-> !clamp_gate); // R6
  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    end_act <= start_act |-> !clamp_gate); // R5
  AST_WINDOW_HELD: assert property (@(posedge clk) disable iff (rst)
    !hs_fall |=> $stable(start_act) && $stable(end_act)); // R7
endmodule

// File: tb/hsync_clamp_gen_tb.sv
module hsync_clamp_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       clamp_gate;

  int checks = 0;
  int fails  = 0;

  hsync_clamp_gen u_dut (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .clamp_gate(clamp_gate)
  );

  always #5 clk = ~clk;

  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {10'd10,  10'd20},
    {10'd0,   10'd1},
    {10'd300, 10'd301},
    {10'd5,   10'd5},
    {10'd40,  10'd7},
    {10'd1000,10'd1023},
    {10'd259, 10'd600},
    {10'd0,   10'd1023},
    {10'd512, 10'd700}
  };

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_times(input logic [9:0] s, input logic [9:0] e);
    wr(2'd0, s[7:0]);
    wr(2'd1, {6'b101101, s[9:8]});
    wr(2'd2, e[7:0]);
    wr(2'd3, {6'b110011, e[9:8]});
  endtask

  task automatic run_line(input bit mid, input logic [7:0] mid_end, output int first, output int width);
    first = -1; width = 0;
    @(negedge clk);
    hsync_n = 1'b0;
    for (int k = 0; k < 1100; k++) begin
      @(negedge clk);
      if (clamp_gate) begin
        if (first < 0) first = k;
        width++;
      end
      if (k == 3) hsync_n = 1'b1;
      wr_en = 1'b0;
      if (mid && k == 5) begin
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = mid_end;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int f, w, hi;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    hi = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (clamp_gate) hi++;
    end
    check("R1", hi, 0, "gate high before first sync");

    run_line(1'b0, 8'h00, f, w);
    check("R4", f, 0, "default first count");
    check("R4", w, 82, "default width");

    for (int v = 0; v < NV; v++) begin
      int s, e, ef, ew;
      s = int'(VEC[v][19:10]);
      e = int'(VEC[v][9:0]);
      ew = (e > s) ? e - s : 0;
      ef = (ew > 0) ? s : -1;
      set_times(VEC[v][19:10], VEC[v][9:0]);
      run_line(1'b0, 8'h00, f, w);
      check(ew == 0 ? "R5" : "R2", f, ef, "first high count");
      check(s > 255 ? "R3" : "R6", w, ew, "pulse width");
    end

    set_times(10'd10, 10'd20);
    run_line(1'b0, 8'h00, f, w);
    check("R2", w, 10, "baseline width");
    run_line(1'b1, 8'd60, f, w);
    check("R7", w, 10, "mid-line write altered current line");
    run_line(1'b0, 8'h00, f, w);
    check("R7", w, 50, "write not applied at next line");
    check("R8", f, 10, "first count after held-low sync");

    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clamp_gate) hi++;
    end
    check("R6", hi, 0, "gate after saturation");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule